// File: doc/BRIEF.md
# Time-Slot Interchange Switching Core

This block moves 8-bit channels between four parallel input streams and four parallel output streams. A frame holds 128 time slots per stream, and one clock cycle is one slot: during a slot every input stream delivers the byte of the channel with that slot number, and every output stream emits the byte for the output channel with that slot number. A frame-start pulse marks slot 0. Between pulses an internal counter advances the slot number once per clock.

Incoming bytes are stored in a data memory addressed by bank, stream and channel. For every output stream and channel, a connection memory entry names the source stream and source channel, enables or mutes that output channel, and selects one of two delay disciplines. Variable delay takes the current frame's byte when the output slot is more than two slots after the input slot. Otherwise it takes the previous frame's byte. Constant delay always takes the byte from two frames before, less the slot offset, so every channel gets the same frame-aligned latency. The data memory rotates through three banks, one per frame.

The output is registered. Each cycle it presents one byte per output stream, the slot number those bytes belong to, a valid flag, and a per-stream drive flag that tells the serial pad stage whether to drive or float that channel.

Top module: `tsi_switch_core`

## Requirements
- R1: `frame_pulse` high in a cycle makes that cycle slot 0. Later cycles count up by one and wrap after 127. The outputs for slot s appear on the clock edge that ends slot s, with `out_slot` = s. `out_valid` stays 0 from reset until the first frame pulse has been seen.
- R2: In variable mode, with source channel n and output channel m where m > n+2, the output byte is the one that entered m−n slots earlier, from the current frame.
- R3: In variable mode, with m equal to n, n+1 or n+2, the output byte is the one that entered m−n+128 slots earlier.
- R4: In variable mode, with m < n, the output byte is the one that entered 128−(n−m) slots earlier.
- R5: In constant mode, the output byte is the one that entered 128+(128−n)+m slots earlier, for every n and m.
- R6: A connection entry is 11 bits. Bits [6:0] hold the source channel, bits [8:7] the source stream, bit 9 the output-enable and bit 10 the mode (0 = variable, 1 = constant). Each output stream and channel may take any input stream and channel.
- R7: When an entry's output-enable is 0, the drive flag of that output stream is 0 for that slot, whatever `drive_en` and `standby_release` are.
- R8: When an entry's output-enable is 1, the drive flag is 1 if `drive_en` or `standby_release` is 1, and 0 only when both are 0.
- R9: Reset clears every connection entry, and afterwards `out_valid` and all drive flags are 0. A connection write, addressed {output stream, channel}, applies to reads from the next cycle onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Marks the current cycle as slot 0 |
| in_bytes | input | 32 | Input byte of the current slot, stream s at bits [8s+7:8s] |
| cm_wr_en | input | 1 | Connection memory write strobe |
| cm_wr_addr | input | 9 | Write address {output stream[1:0], channel[6:0]} |
| cm_wr_data | input | 11 | Entry value, fields as in R6 |
| drive_en | input | 1 | Global output drive enable |
| standby_release | input | 1 | Drives the outputs even when `drive_en` is 0 |
| out_bytes | output | 32 | Switched bytes, output stream o at bits [8o+7:8o] |
| out_valid | output | 1 | Outputs belong to a counted slot |
| out_slot | output | 7 | Slot number of the presented bytes |
| out_drive | output | 4 | Per-stream drive flag for the presented slot |

## Verification
Random bytes enter on all four streams in every slot. Each output byte is compared with the byte that entered exactly the expected number of slots earlier, so a delay that is off by one slot or one frame shows up as a value mismatch. Directed entries fix (n, m) pairs at the variable-mode borders m = n+3, n+2, n+1, n and m < n, at the frame-wrap pairs (127→0, 0→127), and at the same pairs in constant mode, which separates current, previous and two-frames-back banks. Random entries with mixed source streams, rewrites in the middle of the run and random toggling of the two drive controls separate the output-enable logic from the routing.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

   // three data banks: current frame, one back, two back
   localparam int unsigned NBANK = 3;

   typedef logic [1:0] bank_t;

   typedef enum logic {
      DLY_VARIABLE = 1'b0,
      DLY_CONSTANT = 1'b1
   } dly_mode_e;

   // step forward modulo NBANK; two steps forward equals one step back
   function automatic bank_t bank_next(bank_t b);
      return (b == bank_t'(NBANK - 1)) ? bank_t'(0) : b + bank_t'(1);
   endfunction

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
   import tsi_pkg::*;
#(
   parameter int unsigned CHANS = 128,
   localparam int unsigned CW   = $clog2(CHANS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_pulse,
   output logic [CW-1:0] slot_o,
   output bank_t         bank_o,
   output logic          live_o
);

   logic [CW-1:0] slot_q;
   bank_t         bank_q;
   logic          live_q;

   always_comb begin
      if (frame_pulse) begin
         slot_o = '0;
         bank_o = bank_next(bank_q);
      end else begin
         slot_o = (slot_q == CW'(CHANS - 1)) ? '0 : slot_q + CW'(1);
         bank_o = bank_q;
      end
   end

   assign live_o = live_q | frame_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= CW'(CHANS - 1);
         bank_q <= '0;
         live_q <= 1'b0;
      end else begin
         slot_q <= slot_o;
         bank_q <= bank_o;
         if (frame_pulse) live_q <= 1'b1;
      end
   end

   // R5
   bank_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> (bank_q != $past(bank_q)));

   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> (bank_q == $past(bank_q)));

   // R5
   bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_q < bank_t'(NBANK));

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int unsigned OUTS  = 4,
   parameter int unsigned CHANS = 128,
   parameter int unsigned EW    = 11,
   localparam int unsigned SW    = $clog2(OUTS),
   localparam int unsigned CW    = $clog2(CHANS),
   localparam int unsigned DEPTH = OUTS * CHANS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SW+CW-1:0]   wr_addr,
   input  logic [EW-1:0]      wr_data,
   input  logic [CW-1:0]      rd_slot,
   output logic [OUTS*EW-1:0] rd_entries
);

   logic [EW-1:0] cm [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cm <= '{default: '0};
      end else if (wr_en) begin
         cm[wr_addr] <= wr_data;
      end
   end

   for (genvar o = 0; o < OUTS; o++) begin : g_rd
      assign rd_entries[o*EW +: EW] = cm[{SW'(o), rd_slot}];
   end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
   import tsi_pkg::*;
#(
   parameter int unsigned STREAMS = 4,
   parameter int unsigned CHANS   = 128,
   parameter int unsigned DW      = 8,
   parameter int unsigned NRD     = 4,
   localparam int unsigned SW     = $clog2(STREAMS),
   localparam int unsigned CW     = $clog2(CHANS),
   localparam int unsigned RAW    = 2 + SW + CW,
   localparam int unsigned DEPTH  = NBANK * STREAMS * CHANS
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  bank_t                  wr_bank,
   input  logic [CW-1:0]          wr_slot,
   input  logic [STREAMS*DW-1:0]  wr_data,
   input  logic [NRD*RAW-1:0]     rd_addr,
   output logic [NRD*DW-1:0]      rd_data
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int s = 0; s < STREAMS; s++) begin
            mem[{wr_bank, SW'(s), wr_slot}] <= wr_data[s*DW +: DW];
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r*DW +: DW] = mem[rd_addr[r*RAW +: RAW]];
   end

endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
   import tsi_pkg::*;
#(
   parameter int unsigned STREAMS = 4,
   parameter int unsigned CHANS   = 128,
   parameter int unsigned DW      = 8,
   localparam int unsigned SW     = $clog2(STREAMS),
   localparam int unsigned CW     = $clog2(CHANS),
   localparam int unsigned EW     = CW + SW + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_pulse,
   input  logic [STREAMS*DW-1:0] in_bytes,
   input  logic                  cm_wr_en,
   input  logic [SW+CW-1:0]      cm_wr_addr,
   input  logic [EW-1:0]         cm_wr_data,
   input  logic                  drive_en,
   input  logic                  standby_release,
   output logic [STREAMS*DW-1:0] out_bytes,
   output logic                  out_valid,
   output logic [CW-1:0]         out_slot,
   output logic [STREAMS-1:0]    out_drive
);

   localparam int unsigned RAW      = 2 + SW + CW;
   localparam int unsigned CW1      = CW + 1;
   localparam int unsigned OE_BIT   = CW + SW;
   localparam int unsigned MODE_BIT = CW + SW + 1;

   if (STREAMS < 2 || (1 << SW) != STREAMS) begin : g_bad_streams
      $error("STREAMS must be a power of two, at least 2");
   end
   if (CHANS < 8 || (1 << CW) != CHANS) begin : g_bad_chans
      $error("CHANS must be a power of two, at least 8");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [CW-1:0]          slot;
   bank_t                  cur_bank;
   logic                   live;
   logic [STREAMS*EW-1:0]  entries;
   logic [STREAMS*RAW-1:0] rd_addr;
   logic [STREAMS*DW-1:0]  rd_data;
   logic [STREAMS-1:0]     drive_d;

   tsi_timebase #(.CHANS(CHANS)) u_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .slot_o      (slot),
      .bank_o      (cur_bank),
      .live_o      (live)
   );

   tsi_conn_mem #(.OUTS(STREAMS), .CHANS(CHANS), .EW(EW)) u_conn_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cm_wr_en),
      .wr_addr    (cm_wr_addr),
      .wr_data    (cm_wr_data),
      .rd_slot    (slot),
      .rd_entries (entries)
   );

   tsi_data_mem #(.STREAMS(STREAMS), .CHANS(CHANS), .DW(DW), .NRD(STREAMS)) u_data_mem (
      .clk     (clk),
      .wr_en   (live),
      .wr_bank (cur_bank),
      .wr_slot (slot),
      .wr_data (in_bytes),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   for (genvar o = 0; o < STREAMS; o++) begin : g_out
      logic [EW-1:0] ent;
      logic [CW-1:0] src_ch;
      logic [SW-1:0] src_st;
      logic          same_frame_ok;
      dly_mode_e     mode;
      bank_t         pick;

      assign ent    = entries[o*EW +: EW];
      assign src_ch = ent[CW-1:0];
      assign src_st = ent[CW +: SW];
      assign mode   = dly_mode_e'(ent[MODE_BIT]);
      // current frame usable only when the output slot trails the input by more than two
      assign same_frame_ok = ({1'b0, slot} > ({1'b0, src_ch} + CW1'(2)));

      always_comb begin
         if (mode == DLY_CONSTANT) begin
            pick = bank_next(cur_bank);               // two frames back
         end else if (same_frame_ok) begin
            pick = cur_bank;                          // this frame
         end else begin
            pick = bank_next(bank_next(cur_bank));    // one frame back
         end
      end

      assign rd_addr[o*RAW +: RAW] = {pick, src_st, src_ch};
      assign drive_d[o] = live & ent[OE_BIT] & (drive_en | standby_release);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_bytes <= '0;
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_drive <= '0;
      end else begin
         out_bytes <= rd_data;
         out_valid <= live;
         out_slot  <= slot;
         out_drive <= drive_d;
      end
   end

   // R1
   first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(frame_pulse));

   // R1
   slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> (out_slot == '0));

   // R8
   quiet_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_en && !standby_release) |=> (out_drive == '0));

endmodule

// File: tb/tsi_switch_core_bench.sv
module tsi_switch_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int S      = 4;
   localparam int C      = 128;
   localparam int DW     = 8;
   localparam int SW     = 2;
   localparam int CW     = 7;
   localparam int EW     = 11;
   localparam int FRAMES = 12;
   localparam int TOT    = FRAMES * C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_pulse = 1'b0;
   logic [S*DW-1:0]   in_bytes = '0;
   logic              cm_wr_en = 1'b0;
   logic [SW+CW-1:0]  cm_wr_addr = '0;
   logic [EW-1:0]     cm_wr_data = '0;
   logic              drive_en = 1'b0;
   logic              standby_release = 1'b0;
   logic [S*DW-1:0]   out_bytes;
   logic              out_valid;
   logic [CW-1:0]     out_slot;
   logic [S-1:0]      out_drive;

   tsi_switch_core u_tsi_switch_core (
      .clk             (clk),
      .rst_n           (rst_n),
      .frame_pulse     (frame_pulse),
      .in_bytes        (in_bytes),
      .cm_wr_en        (cm_wr_en),
      .cm_wr_addr      (cm_wr_addr),
      .cm_wr_data      (cm_wr_data),
      .drive_en        (drive_en),
      .standby_release (standby_release),
      .out_bytes       (out_bytes),
      .out_valid       (out_valid),
      .out_slot        (out_slot),
      .out_drive       (out_drive)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [DW-1:0]    hist [TOT][S];
   logic [EW-1:0]    cm_m [S*C];
   bit               pend_v = 0;
   logic [SW+CW-1:0] pend_a;
   logic [EW-1:0]    pend_d;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected latency in slots from the requirement formulas
   function automatic int delay_of(bit mode, int n, int m);
      if (mode) return C + (C - n) + m;      // R5
      if (m > n + 2) return m - n;           // R2
      if (m >= n) return m - n + C;          // R3
      return C - (n - m);                    // R4
   endfunction

   function automatic string req_of(bit mode, int n, int m);
      if (mode) return "R5";
      if (m > n + 2) return "R2";
      if (m >= n) return "R3";
      return "R4";
   endfunction

   function automatic logic [EW-1:0] mk(bit mode, bit oe, int ss, int sc);
      return {mode, oe, SW'(ss), CW'(sc)};
   endfunction

   task automatic cm_setup(input int o, input int ch, input logic [EW-1:0] e);
      @(negedge clk);
      cm_wr_en   = 1'b1;
      cm_wr_addr = {SW'(o), CW'(ch)};
      cm_wr_data = e;
      cm_m[o*C + ch] = e;
   endtask

   task automatic check_outputs(input int a);
      int m;
      m = a % C;
      check("R1 valid", int'(out_valid), 1);
      check("R1 slot", int'(out_slot), m);
      for (int o = 0; o < S; o++) begin
         logic [EW-1:0] e;
         int sc, ss, src, exp_drv;
         bit mode, oe;
         e    = cm_m[o*C + m];
         sc   = int'(e[6:0]);
         ss   = int'(e[8:7]);
         oe   = e[9];
         mode = e[10];
         exp_drv = (oe && (drive_en || standby_release)) ? 1 : 0;
         check(oe ? "R8 drive" : "R7 R9 drive", int'(out_drive[o]), exp_drv);
         src = a - delay_of(mode, sc, m);
         if (src >= 0)
            check($sformatf("%s R6 data o=%0d m=%0d n=%0d", req_of(mode, sc, m), o, m, sc),
                  int'(out_bytes[o*DW +: DW]), int'(hist[src][ss]));
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < S*C; i++) cm_m[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state, and no valid output before the first frame pulse (R1)
      check("R9 reset valid", int'(out_valid), 0);
      check("R9 reset drive", int'(out_drive), 0);
      check("R1 no pulse yet", int'(out_valid), 0);

      // directed corner pairs, all enabled
      cm_setup(0,  10, mk(0, 1, 1,   7));   // m = n+3, R2
      cm_setup(0,  20, mk(0, 1, 2,  18));   // m = n+2, R3
      cm_setup(0,  30, mk(0, 1, 3,  30));   // m = n, R3
      cm_setup(0,  40, mk(0, 1, 0,  45));   // m < n, R4
      cm_setup(0,   0, mk(0, 1, 1, 127));   // wrap pair, R4
      cm_setup(0, 127, mk(0, 1, 2,   0));   // widest same-frame, R2
      cm_setup(1,   3, mk(1, 1, 3,   3));   // R5
      cm_setup(1,   0, mk(1, 1, 0, 127));   // R5
      cm_setup(1, 127, mk(1, 1, 1,   0));   // R5
      cm_setup(1,  11, mk(0, 1, 2,   8));   // m = n+3, R2
      cm_setup(1,  21, mk(0, 1, 0,  20));   // m = n+1, R3
      // random entries; stream 3 channel 50 stays at its reset value
      for (int i = 0; i < 80; i++) begin
         int o, ch;
         o  = int'($urandom_range(2, 0));
         ch = int'($urandom_range(C-1, 0));
         if (o == 0 && (ch == 10 || ch == 20 || ch == 30 || ch == 40 || ch == 0 || ch == 127))
            continue;
         if (o == 1 && (ch == 3 || ch == 0 || ch == 127 || ch == 11 || ch == 21))
            continue;
         cm_setup(o, ch, EW'($urandom));
      end
      for (int ch = 0; ch < C; ch += 3)
         if (ch != 50) cm_setup(3, ch, mk($urandom_range(1, 0), 1, $urandom_range(3, 0), $urandom_range(C-1, 0)));
      @(negedge clk);
      cm_wr_en = 1'b0;
      drive_en = 1'b1;

      for (int t = 0; t <= TOT; t++) begin
         if (t > 0) @(negedge clk);
         if (t > 0) check_outputs(t - 1);
         if (pend_v) begin
            cm_m[pend_a] = pend_d;   // R9: write seen from the next read on
            pend_v = 0;
         end
         if (t == TOT) break;
         frame_pulse = (t % C == 0);
         for (int s = 0; s < S; s++) begin
            hist[t][s] = DW'($urandom);
            in_bytes[s*DW +: DW] = hist[t][s];
         end
         if (t >= 5*C && t < 7*C && ($urandom % 8) == 0) begin
            pend_a = (SW+CW)'($urandom);
            pend_d = EW'($urandom);
            pend_v = 1;
            cm_wr_en   = 1'b1;
            cm_wr_addr = pend_a;
            cm_wr_data = pend_d;
         end else begin
            cm_wr_en = 1'b0;
         end
         if (t % 37 == 5) begin
            drive_en        = 1'($urandom);
            standby_release = 1'($urandom);
         end
      end
      frame_pulse = 1'b0;
      finish_run();
   end

endmodule